// File: doc/BRIEF.md
# SMBus Bus Timeout Monitor

This block watches the clock and data lines of an SMBus or I2C bus and measures the lines against five timing limits at once. The limits are clock-cycle counts that come from registers. It times how long the clock stays low, how long both lines stay high, and how long data stays low while the clock is high. Within each byte segment it also adds up how long the local master and the local slave have held the clock low. It follows START, STOP and the acknowledge slot to keep a bus-busy state and to mark where each segment begins and ends.

Each timing violation sets its own sticky flag. The flags stay set until a write-one-to-clear strobe removes them. A masked OR of the flags drives one interrupt request. The attached protocol logic reads two abort indications. In master mode a level asks for a STOP at the end of the current byte. In slave mode a single-cycle pulse tells the receiver to drop its state and wait for a new START. The monitor does not shift data, decode addresses or transfer bytes.

Top module: `smbus_tmo_monitor`

## Requirements
- R1: Both lines pass through a synchronizer. A falling data edge while the clock is high (a START) sets `busBusy`. A rising data edge while the clock is high (a STOP) clears it.
- R2: After both synchronized lines have been high for `highLimit` consecutive cycles or more, `flags[1]` (idle timeout) sets. `busIdle` reads 1 whenever `busBusy` is 0 or `flags[1]` is set.
- R3: `busHung` reads 1 exactly when `busBusy` and `flags[1]` are both set. This is a high timeout seen after a START with no STOP following it.
- R4: After data has been low while the clock is high for more than `sdaLowLimit` consecutive cycles, `flags[2]` sets.
- R5: After the synchronized clock has been low for more than `lowLimit` consecutive cycles, `flags[0]` sets. With `masterMode`=1, `masterStopReq` follows `flags[0]`. With `masterMode`=0, `slaveReset` pulses for one cycle in the cycle where `flags[0]` rises.
- R6: Cycles where the synchronized clock is low and `masterStretch` is 1 add up within a segment. A segment ends at START, at STOP, and at the 9th clock rise after a START or after the previous acknowledge. When the total goes over `mextLimit`, `flags[3]` sets and so does `flags[0]`.
- R7: Cycles where the clock is low and `slaveStretch` is 1 add up in the same way against `sextLimit`. Going over the limit sets `flags[4]` only and leaves `flags[0]` alone.
- R8: Flags are sticky. A 1 in `flagClr` clears the matching flag in the next cycle, unless its set condition holds in that same cycle, in which case the set wins.
- R9: `irq` is the OR of `flags & irqEnable`. The bit positions are 0 clock low, 1 idle high, 2 data low, 3 master extension, 4 slave extension.
- R10: Each period timer starts again from zero whenever the condition it measures goes false, so separate short runs never add up to a timeout.
- R11: After reset all flags are 0, `busBusy` is 0, and `irq`, `masterStopReq` and `slaveReset` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| masterMode | input | 1 | 1 when the local controller acts as master |
| masterStretch | input | 1 | Local master is holding the clock low |
| slaveStretch | input | 1 | Local slave is holding the clock low |
| lowLimit | input | CNT_W | Clock-low timeout limit in cycles |
| highLimit | input | CNT_W | Both-high idle limit in cycles |
| sdaLowLimit | input | CNT_W | Data-low-with-clock-high limit in cycles |
| mextLimit | input | CNT_W | Master cumulative extension limit per segment |
| sextLimit | input | CNT_W | Slave cumulative extension limit per segment |
| flagClr | input | 5 | Write-one-to-clear strobes, one per flag |
| irqEnable | input | 5 | Interrupt enable mask, one per flag |
| flags | output | 5 | Sticky timeout flags |
| irq | output | 1 | Combined interrupt request |
| busBusy | output | 1 | A START has been seen and no STOP since |
| busIdle | output | 1 | Bus is free for a new transfer |
| busHung | output | 1 | Idle timeout reached while the bus is busy |
| masterStopReq | output | 1 | Master should issue a STOP after the current byte |
| slaveReset | output | 1 | One-cycle pulse telling the slave to drop its state |

## Verification
The bench builds the monitor with `CNT_W` set to 6 and two synchronizer stages. It uses limits between 10 and 30 cycles, so every timeout in the set can fire within a few hundred cycles. A bit period of eight cycles, with the clock low for four, makes each stretched bit add exactly four cycles to an extension total. A limit of 10 therefore separates two stretched bits in a segment from three. This lets the bench show that the acknowledge boundary resets the total: two segments of eight cycles each stay clean, while without that reset they would sum to sixteen.

// File: rtl/smbus_tmo_pkg.sv
package smbus_tmo_pkg;

  localparam int FLAG_N    = 5;
  localparam int FLAG_LOW  = 0;
  localparam int FLAG_IDLE = 1;
  localparam int FLAG_SDA  = 2;
  localparam int FLAG_MEXT = 3;
  localparam int FLAG_SEXT = 4;

  // strobes and levels handed from the bus control to the timing datapath
  typedef struct packed {
    logic startDet;
    logic stopDet;
    logic ackDet;
    logic segClr;
    logic sclLow;
    logic bothHigh;
    logic sdaLowSclHigh;
  } busEvt_t;

endpackage

// File: rtl/smbus_tmo_counter.sv
module smbus_tmo_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] nxt
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt;

  always_comb begin
    if (clr)                        nxt = '0;
    else if (inc && cnt != CNT_MAX) nxt = cnt + 1'b1;
    else                            nxt = cnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else       cnt <= nxt;
  end
endmodule

// File: rtl/smbus_tmo_ctrl.sv
module smbus_tmo_ctrl
  import smbus_tmo_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SEG_BITS    = 9
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclIn,
  input  logic    sdaIn,
  output busEvt_t evt,
  output logic    busBusy
);
  localparam int BIT_W = $clog2(SEG_BITS + 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(SEG_BITS - 1);

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclNow, sdaNow, sclPrev, sdaPrev;
  logic sclRise;
  logic [BIT_W-1:0] bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  assign sclNow  = sclSync[SYNC_STAGES-1];
  assign sdaNow  = sdaSync[SYNC_STAGES-1];
  assign sclRise = sclNow & ~sclPrev;

  always_comb begin
    evt.startDet      = sclNow & sclPrev & sdaPrev & ~sdaNow;
    evt.stopDet       = sclNow & sclPrev & ~sdaPrev & sdaNow;
    evt.ackDet        = sclRise & (bitCnt == LAST_BIT) & busBusy;
    evt.segClr        = evt.startDet | evt.stopDet | evt.ackDet;
    evt.sclLow        = ~sclNow;
    evt.bothHigh      = sclNow & sdaNow;
    evt.sdaLowSclHigh = sclNow & ~sdaNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busBusy <= 1'b0;
      bitCnt  <= '0;
    end else begin
      if (evt.startDet)     busBusy <= 1'b1;
      else if (evt.stopDet) busBusy <= 1'b0;

      if (evt.startDet) bitCnt <= '0;
      else if (sclRise) bitCnt <= (bitCnt == LAST_BIT) ? '0 : bitCnt + 1'b1;
    end
  end
endmodule

// File: rtl/smbus_tmo_datapath.sv
module smbus_tmo_datapath
  import smbus_tmo_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  busEvt_t           evt,
  input  logic              masterMode,
  input  logic              masterStretch,
  input  logic              slaveStretch,
  input  logic [CNT_W-1:0]  lowLimit,
  input  logic [CNT_W-1:0]  highLimit,
  input  logic [CNT_W-1:0]  sdaLowLimit,
  input  logic [CNT_W-1:0]  mextLimit,
  input  logic [CNT_W-1:0]  sextLimit,
  input  logic [FLAG_N-1:0] flagClr,
  output logic [FLAG_N-1:0] flags,
  output logic              slaveReset
);
  localparam int CNT_N = 5;

  // counter slots: 0 clock low, 1 both high, 2 data low, 3 master ext, 4 slave ext
  logic [CNT_N-1:0] cClr, cInc;
  logic [CNT_W-1:0] cNxt [CNT_N];
  logic [FLAG_N-1:0] flagSet;
  logic mextHit;

  assign cClr = {evt.segClr, evt.segClr, ~evt.sdaLowSclHigh, ~evt.bothHigh, ~evt.sclLow};
  assign cInc = {evt.sclLow & slaveStretch, evt.sclLow & masterStretch,
                 evt.sdaLowSclHigh, evt.bothHigh, evt.sclLow};

  for (genvar g = 0; g < CNT_N; g++) begin : g_cnt
    smbus_tmo_counter #(.W(CNT_W)) u_cnt (
      .clk (clk),
      .rstN(rstN),
      .clr (cClr[g]),
      .inc (cInc[g]),
      .nxt (cNxt[g])
    );
  end

  assign mextHit = cNxt[3] > mextLimit;

  always_comb begin
    flagSet            = '0;
    flagSet[FLAG_LOW]  = (cNxt[0] > lowLimit) | mextHit;
    flagSet[FLAG_IDLE] = cNxt[1] >= highLimit;
    flagSet[FLAG_SDA]  = cNxt[2] > sdaLowLimit;
    flagSet[FLAG_MEXT] = mextHit;
    flagSet[FLAG_SEXT] = cNxt[4] > sextLimit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags      <= '0;
      slaveReset <= 1'b0;
    end else begin
      flags      <= (flags & ~flagClr) | flagSet;
      slaveReset <= ~masterMode & flagSet[FLAG_LOW] & ~flags[FLAG_LOW];
    end
  end
endmodule

// File: rtl/smbus_tmo_monitor.sv
module smbus_tmo_monitor
  import smbus_tmo_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int SEG_BITS    = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              masterMode,
  input  logic              masterStretch,
  input  logic              slaveStretch,
  input  logic [CNT_W-1:0]  lowLimit,
  input  logic [CNT_W-1:0]  highLimit,
  input  logic [CNT_W-1:0]  sdaLowLimit,
  input  logic [CNT_W-1:0]  mextLimit,
  input  logic [CNT_W-1:0]  sextLimit,
  input  logic [FLAG_N-1:0] flagClr,
  input  logic [FLAG_N-1:0] irqEnable,
  output logic [FLAG_N-1:0] flags,
  output logic              irq,
  output logic              busBusy,
  output logic              busIdle,
  output logic              busHung,
  output logic              masterStopReq,
  output logic              slaveReset
);
  busEvt_t evt;

  smbus_tmo_ctrl #(.SYNC_STAGES(SYNC_STAGES), .SEG_BITS(SEG_BITS)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .sclIn  (sclIn),
    .sdaIn  (sdaIn),
    .evt    (evt),
    .busBusy(busBusy)
  );

  smbus_tmo_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .evt          (evt),
    .masterMode   (masterMode),
    .masterStretch(masterStretch),
    .slaveStretch (slaveStretch),
    .lowLimit     (lowLimit),
    .highLimit    (highLimit),
    .sdaLowLimit  (sdaLowLimit),
    .mextLimit    (mextLimit),
    .sextLimit    (sextLimit),
    .flagClr      (flagClr),
    .flags        (flags),
    .slaveReset   (slaveReset)
  );

  assign irq           = |(flags & irqEnable);
  assign busIdle       = ~busBusy | flags[FLAG_IDLE];
  assign busHung       = busBusy & flags[FLAG_IDLE];
  assign masterStopReq = masterMode & flags[FLAG_LOW];
endmodule

// File: rtl/smbus_tmo_checker.sv
module smbus_tmo_checker
  import smbus_tmo_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              masterMode,
  input logic [FLAG_N-1:0] flagClr,
  input logic [FLAG_N-1:0] flags,
  input logic              busBusy,
  input logic              busIdle,
  input logic              busHung,
  input logic              slaveReset
);
  // R8: a flag that is set and not cleared stays set
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((flags & ~flagClr) != '0) |=> ((flags & $past(flags & ~flagClr)) == $past(flags & ~flagClr)));

  // R6: a master extension timeout also raises the clock-low flag
  assert_mext_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[FLAG_MEXT]) |-> flags[FLAG_LOW]);

  // R5: the slave reset pulse only comes with a rising clock-low flag in slave mode
  assert_slave_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    slaveReset |-> ($rose(flags[FLAG_LOW]) && !$past(masterMode)));

  // R5: the pulse lasts a single cycle
  assert_slave_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    slaveReset |=> !slaveReset);

  // R3: a hung bus is busy and reported idle for recovery
  assert_hung_state_R3: assert property (@(posedge clk) disable iff (!rstN)
    busHung |-> (busBusy && busIdle));
endmodule

bind smbus_tmo_monitor smbus_tmo_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .masterMode(masterMode),
  .flagClr   (flagClr),
  .flags     (flags),
  .busBusy   (busBusy),
  .busIdle   (busIdle),
  .busHung   (busHung),
  .slaveReset(slaveReset)
);

// File: tb/tb_smbus_tmo_monitor.sv
`timescale 1ns/1ps
module tb_smbus_tmo_monitor;
  localparam int CW   = 6;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rstN;
  logic sclIn, sdaIn, masterMode, masterStretch, slaveStretch;
  logic [CW-1:0] lowLimit, highLimit, sdaLowLimit, mextLimit, sextLimit;
  logic [4:0] flagClr, irqEnable, flags;
  logic irq, busBusy, busIdle, busHung, masterStopReq, slaveReset;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  smbus_tmo_monitor #(.CNT_W(CW), .SYNC_STAGES(2), .SEG_BITS(9)) dut (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .masterMode(masterMode), .masterStretch(masterStretch), .slaveStretch(slaveStretch),
    .lowLimit(lowLimit), .highLimit(highLimit), .sdaLowLimit(sdaLowLimit),
    .mextLimit(mextLimit), .sextLimit(sextLimit),
    .flagClr(flagClr), .irqEnable(irqEnable), .flags(flags), .irq(irq),
    .busBusy(busBusy), .busIdle(busIdle), .busHung(busHung),
    .masterStopReq(masterStopReq), .slaveReset(slaveReset)
  );

  // behavioural reference model
  int mSc1, mSc2, mScP, mSd1, mSd2, mSdP;
  int mLow, mHigh, mSdl, mMext, mSext, mBit;
  bit mBusy, mSlvRst;
  bit [4:0] mFlags;

  function automatic int satInc(int v);
    return (v >= MAXC) ? MAXC : v + 1;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mSc1 = 1; mSc2 = 1; mScP = 1; mSd1 = 1; mSd2 = 1; mSdP = 1;
      mLow = 0; mHigh = 0; mSdl = 0; mMext = 0; mSext = 0; mBit = 0;
      mBusy = 0; mSlvRst = 0; mFlags = '0;
    end else begin
      bit st, sp, rise, ack, seg;
      bit [4:0] setV;
      st   = mSc2 && mScP && mSdP && !mSd2;
      sp   = mSc2 && mScP && !mSdP && mSd2;
      rise = mSc2 && !mScP;
      ack  = rise && mBit == 8 && mBusy;
      seg  = st || sp || ack;
      mLow  = (mSc2 == 0) ? satInc(mLow) : 0;
      mHigh = (mSc2 == 1 && mSd2 == 1) ? satInc(mHigh) : 0;
      mSdl  = (mSc2 == 1 && mSd2 == 0) ? satInc(mSdl) : 0;
      if (seg) mMext = 0; else if (mSc2 == 0 && masterStretch) mMext = satInc(mMext);
      if (seg) mSext = 0; else if (mSc2 == 0 && slaveStretch)  mSext = satInc(mSext);
      setV[3] = mMext > int'(mextLimit);
      setV[0] = (mLow > int'(lowLimit)) || setV[3];
      setV[1] = mHigh >= int'(highLimit);
      setV[2] = mSdl > int'(sdaLowLimit);
      setV[4] = mSext > int'(sextLimit);
      mSlvRst = !masterMode && setV[0] && !mFlags[0];
      mFlags  = (mFlags & ~flagClr) | setV;
      if (st) mBusy = 1; else if (sp) mBusy = 0;
      if (st) mBit = 0; else if (rise) mBit = (mBit == 8) ? 0 : mBit + 1;
      mScP = mSc2; mSc2 = mSc1; mSc1 = sclIn;
      mSdP = mSd2; mSd2 = mSd1; mSd1 = sdaIn;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, sampled after the edge has settled
  always @(posedge clk) begin
    #2;
    if (rstN && !finished) begin
      check("R1 busBusy",       busBusy,       mBusy);
      check("R2 busIdle",       busIdle,       !mBusy || mFlags[1]);
      check("R3 busHung",       busHung,       mBusy && mFlags[1]);
      check("R5 flag low",      flags[0],      mFlags[0]);
      check("R2 flag idle",     flags[1],      mFlags[1]);
      check("R4 flag sda",      flags[2],      mFlags[2]);
      check("R6 flag mext",     flags[3],      mFlags[3]);
      check("R7 flag sext",     flags[4],      mFlags[4]);
      check("R9 irq",           irq,           |(mFlags & irqEnable));
      check("R5 masterStopReq", masterStopReq, masterMode && mFlags[0]);
      check("R5 slaveReset",    slaveReset,    mSlvRst);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clearFlags(input logic [4:0] m);
    flagClr = m;
    tick(1);
    flagClr = '0;
  endtask

  task automatic sendBit(input logic b, input logic m, input logic s);
    masterStretch = m;
    slaveStretch  = s;
    sclIn = 1'b0;
    tick(1);
    sdaIn = b;
    tick(3);
    sclIn = 1'b1;
    tick(4);
    masterStretch = 1'b0;
    slaveStretch  = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [8:0] pat;
    pat = 9'b1010_0101_0;
    rstN = 1'b0; sclIn = 1'b1; sdaIn = 1'b1;
    masterMode = 1'b1; masterStretch = 1'b0; slaveStretch = 1'b0;
    lowLimit = 6'd20; highLimit = 6'd30; sdaLowLimit = 6'd12;
    mextLimit = 6'd10; sextLimit = 6'd10;
    flagClr = '0; irqEnable = 5'b00010;
    tick(4);
    rstN = 1'b1;
    tick(1);
    check("R11 reset flags", flags, 5'd0);
    check("R11 reset busy", busBusy, 1'b0);
    check("R11 reset irq/stop/pulse", {irq, masterStopReq, slaveReset}, 3'b000);

    tick(40);
    check("R2 idle flag after long high", flags[1], 1'b1);
    check("R2 busIdle", busIdle, 1'b1);
    check("R9 irq with idle enabled", irq, 1'b1);

    sdaIn = 1'b0;                       // START
    tick(4);
    check("R1 busy after START", busBusy, 1'b1);
    check("R3 hung while busy", busHung, 1'b1);
    clearFlags(5'b00010);
    tick(1);
    check("R8 idle flag cleared", flags[1], 1'b0);
    tick(20);
    check("R4 sda-low flag", flags[2], 1'b1);
    clearFlags(5'b00100);
    tick(1);
    check("R8 set wins over clear", flags[2], 1'b1);

    // byte 1: three master-stretched bits exceed the extension limit
    for (int i = 0; i < 3; i++) sendBit(pat[8-i], 1'b1, 1'b0);
    check("R6 mext flag", flags[3], 1'b1);
    check("R6 mext raises low flag", flags[0], 1'b1);
    irqEnable = 5'b10000;
    tick(1);
    check("R9 irq masked", irq, 1'b0);
    for (int i = 3; i < 9; i++) sendBit(pat[8-i], 1'b0, 1'b0);
    clearFlags(5'b11111);
    tick(1);
    check("R6 ack cleared accumulator", flags[3], 1'b0);

    // bytes 2 and 3: two stretched bits each, separated by the ack boundary
    for (int k = 0; k < 2; k++)
      for (int i = 0; i < 9; i++) sendBit(pat[8-i], i < 2, 1'b0);
    check("R6 per-segment accumulation", flags[3], 1'b0);

    // byte 4: slave stretch
    for (int i = 0; i < 3; i++) sendBit(pat[8-i], 1'b0, 1'b1);
    check("R7 sext flag", flags[4], 1'b1);
    check("R7 sext leaves low flag", flags[0], 1'b0);
    irqEnable = 5'b10001;
    for (int i = 3; i < 9; i++) sendBit(pat[8-i], 1'b0, 1'b0);

    // slave-mode clock low timeout
    masterMode = 1'b0;
    clearFlags(5'b11111);
    sclIn = 1'b0;
    tick(30);
    check("R5 low flag slave", flags[0], 1'b1);
    check("R5 no stop request in slave", masterStopReq, 1'b0);
    sclIn = 1'b1;
    tick(4);

    // master-mode clock low timeout
    clearFlags(5'b11111);
    masterMode = 1'b1;
    sclIn = 1'b0;
    tick(30);
    check("R5 stop request in master", masterStopReq, 1'b1);
    sclIn = 1'b1;
    tick(4);
    clearFlags(5'b11111);
    tick(2);
    check("R8 low flag cleared", flags[0], 1'b0);

    // two short low runs must not combine
    sclIn = 1'b0; tick(15);
    sclIn = 1'b1; tick(2);
    sclIn = 1'b0; tick(15);
    check("R10 timer restarts", flags[0], 1'b0);

    // STOP
    tick(1);
    sdaIn = 1'b0; tick(2);
    sclIn = 1'b1; tick(4);
    sdaIn = 1'b1; tick(4);
    check("R1 idle after STOP", busBusy, 1'b0);
    tick(40);
    check("R2 idle flag after STOP", flags[1], 1'b1);
    check("R3 not hung when free", busHung, 1'b0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule